// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block orders the start-up of a switching regulator controller. It watches two already-synchronized comparator flags, one saying the bias supply is healthy and one saying the enable/compensation node has climbed past its trip level. Only when both are true does it begin timing. It first holds the low-side driver off and turns on the overcurrent sense current for a fixed settling interval, then asks the overcurrent sampler to capture its level, waits for that sampler to report completion (this phase may take any length of time), and then fires the soft-start ramp. A running flag is raised once the ramp reports that it has finished.

The settling interval is built from a clock prescaler that produces a tick, and a tick counter, both set by parameters. At the defaults (250 clocks per tick, 6800 ticks) a 250 MHz clock gives the nominal 6.8 ms. Losing the bias flag in any state returns the sequencer to its off state. Losing the enable flag after timing has begun sends it back to wait for enable, and the whole settling interval then runs again.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst_n` is low, or `bias_ok` is low, the outputs are `lsd_off`=1, `sense_en`=0, `ocs_start`=0, `ss_start`=0, `running`=0.
- R2: Timing starts only when `bias_ok` and `en_trip` are both high. With `bias_ok` high and `en_trip` low, the outputs keep their off values for any length of time. When both flags are high, `sense_en` rises one cycle after the clock edge that first sees both.
- R3: During the settling and sampling phases, `lsd_off`=1 and `sense_en`=1.
- R4: `sense_en` is high for exactly TICK_DIV*DELAY_TICKS cycles before the cycle in which `ocs_start` pulses.
- R5: `ocs_start` is a single-cycle pulse in the first cycle of the sampling phase. Sampling lasts until `ocs_done` is seen high. `ocs_done` has no effect in any other phase.
- R6: The cycle after `ocs_done` is seen during sampling, `ss_start` pulses for one cycle, and `lsd_off` and `sense_en` are both 0 for the whole ramp phase.
- R7: `running` rises the cycle after `ss_done` is seen during the ramp phase, and stays high while both flags stay high.
- R8: A low `bias_ok` forces the off outputs on the next cycle from any phase. It takes priority over an enable loss and over a done input arriving in the same cycle.
- R9: A low `en_trip` after timing has begun gives the off outputs on the next cycle, including in the cycle when the settling interval would have expired. A later re-enable runs the full settling interval again.
- R10: `ss_done` has no effect outside the ramp phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bias_ok | input | 1 | Synchronized bias-supply-healthy flag |
| en_trip | input | 1 | Synchronized flag: enable node above trip level |
| ocs_done | input | 1 | Overcurrent sampler reports capture complete |
| ss_done | input | 1 | Soft-start ramp reports completion |
| lsd_off | output | 1 | Low-side driver held disabled |
| sense_en | output | 1 | Overcurrent sense current enabled |
| ocs_start | output | 1 | One-cycle strobe starting the overcurrent sample |
| ss_start | output | 1 | One-cycle strobe starting soft-start |
| running | output | 1 | Sequence complete, converter regulating |

## Verification
Two coincidences matter most. The first is an enable loss in the very cycle the settling counter expires. The bench drops `en_trip` exactly on the edge that would move the machine to sampling, and expects the off outputs with no `ocs_start` pulse. The second is a bias loss in the same cycle as a sampler done. It is provoked by raising `ocs_done` while lowering `bias_ok`, and judged by the absence of `ss_start` and a return to the off outputs; the bench then re-enters and also checks that the full interval restarts.

// File: rtl/pwrseq_pkg.sv
// Package: shared state type and output decode for the power-up sequencer.
// Assumes a single clock domain with all inputs already synchronized.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,
        PS_WAIT   = 3'd1,
        PS_SETTLE = 3'd2,
        PS_SAMPLE = 3'd3,
        PS_RAMP   = 3'd4,
        PS_RUN    = 3'd5
    } pseq_state_t;

    typedef struct packed {
        logic lsd_off;
        logic sense_en;
        logic running;
    } pseq_level_t;

    // Level outputs as a pure function of the phase.
    function automatic pseq_level_t level_of(pseq_state_t s);
        pseq_level_t l;
        l.lsd_off  = (s == PS_OFF) || (s == PS_WAIT) ||
                     (s == PS_SETTLE) || (s == PS_SAMPLE);
        l.sense_en = (s == PS_SETTLE) || (s == PS_SAMPLE);
        l.running  = (s == PS_RUN);
        return l;
    endfunction

endpackage

// File: rtl/pwrseq_tick.sv
// Prescaler: while run is high it emits a one-cycle tick every TICK_DIV
// clocks, the first tick in the TICK_DIV-th cycle of run. While run is low
// it is held cleared, so every run interval starts from a known phase.
module pwrseq_tick #(
    parameter int TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_direct
            // Every clock of run is a tick; no counter is needed.
            assign tick = run;
        end else begin : g_count
            localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_q;

            // Count clocks within one tick period; clear outside run.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    pre_q <= '0;
                end else if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = run && (pre_q == PRE_LAST);
        end
    endgenerate

endmodule

// File: rtl/pwrseq_delay.sv
// Settling counter: counts ticks while run is high and raises expired in the
// cycle holding the DELAY_TICKS-th tick. It assumes ticks only come while run
// is high, and it clears whenever run is low.
module pwrseq_delay #(
    parameter int DELAY_TICKS = 6800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DELAY_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Accumulate ticks seen during the current settling interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = tick && (cnt_q == CNT_LAST);

endmodule

// File: rtl/pwrseq_fsm.sv
// Phase machine: orders off, wait-for-enable, settle, sample, ramp and run.
// A low bias_ok beats every other condition. A low en_trip beats every
// done input. The strobes are registered and high in the first cycle of
// their phase.
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bias_ok,
    input  logic        en_trip,
    input  logic        delay_done,
    input  logic        ocs_done,
    input  logic        ss_done,
    output pseq_state_t state,
    output logic        ocs_start,
    output logic        ss_start
);
    pseq_state_t state_q, state_d;
    logic        ocs_q, ss_q;

    // Next-phase selection with bias, then enable, taking priority.
    always_comb begin
        state_d = state_q;
        if (!bias_ok) begin
            state_d = PS_OFF;
        end else begin
            unique case (state_q)
                PS_OFF:    state_d = en_trip ? PS_SETTLE : PS_WAIT;
                PS_WAIT:   if (en_trip) state_d = PS_SETTLE;
                PS_SETTLE: if (!en_trip) state_d = PS_WAIT;
                           else if (delay_done) state_d = PS_SAMPLE;
                PS_SAMPLE: if (!en_trip) state_d = PS_WAIT;
                           else if (ocs_done) state_d = PS_RAMP;
                PS_RAMP:   if (!en_trip) state_d = PS_WAIT;
                           else if (ss_done) state_d = PS_RUN;
                PS_RUN:    if (!en_trip) state_d = PS_WAIT;
                default:   state_d = PS_OFF;
            endcase
        end
    end

    // Phase register and entry strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
            ocs_q   <= 1'b0;
            ss_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ocs_q   <= (state_d == PS_SAMPLE) && (state_q != PS_SAMPLE);
            ss_q    <= (state_d == PS_RAMP) && (state_q != PS_RAMP);
        end
    end

    assign state     = state_q;
    assign ocs_start = ocs_q;
    assign ss_start  = ss_q;

endmodule

// File: rtl/pwrseq_ctrl.sv
// Top: power-up sequencer for a switching regulator controller. It ties the
// prescaler and the settling counter, both running only in the settle phase,
// to the phase machine, and decodes the level outputs from the phase. The
// inputs are assumed synchronized to clk.
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int TICK_DIV    = 250,
    parameter int DELAY_TICKS = 6800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bias_ok,
    input  logic en_trip,
    input  logic ocs_done,
    input  logic ss_done,
    output logic lsd_off,
    output logic sense_en,
    output logic ocs_start,
    output logic ss_start,
    output logic running
);
    pseq_state_t state;
    pseq_level_t lvl;
    logic        settling;
    logic        tick;
    logic        delay_done;

    assign settling = (state == PS_SETTLE);

    pwrseq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settling),
        .tick  (tick)
    );

    pwrseq_delay #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (settling),
        .tick    (tick),
        .expired (delay_done)
    );

    pwrseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bias_ok    (bias_ok),
        .en_trip    (en_trip),
        .delay_done (delay_done),
        .ocs_done   (ocs_done),
        .ss_done    (ss_done),
        .state      (state),
        .ocs_start  (ocs_start),
        .ss_start   (ss_start)
    );

    // Level outputs follow the phase register.
    always_comb begin
        lvl = level_of(state);
    end

    assign lsd_off  = lvl.lsd_off;
    assign sense_en = lvl.sense_en;
    assign running  = lvl.running;

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
// Checker: port-level properties of the power-up sequencer, bound to the top.
// It keeps a saturating run-length counter of sense_en to check the settling
// window without a deep $past.
module pwrseq_ctrl_chk #(
    parameter int TICK_DIV    = 250,
    parameter int DELAY_TICKS = 6800
) (
    input logic clk,
    input logic rst_n,
    input logic bias_ok,
    input logic en_trip,
    input logic ocs_done,
    input logic ss_done,
    input logic lsd_off,
    input logic sense_en,
    input logic ocs_start,
    input logic ss_start,
    input logic running
);
    localparam int WIN = TICK_DIV * DELAY_TICKS;
    localparam int RW  = $clog2(WIN + 2) + 1;
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};

    logic [RW-1:0] sense_run;

    // Length of the current unbroken sense_en stretch, before this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !sense_en) begin
            sense_run <= '0;
        end else if (sense_run != RMAX) begin
            sense_run <= sense_run + 1'b1;
        end
    end

    // R1 / R8: a low bias flag yields the off outputs next cycle.
    a_r8_bias_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_ok |=> (lsd_off && !sense_en && !ocs_start && !ss_start && !running));

    // R2: no sense current right after enable is seen low.
    a_r2_no_sense_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_trip |=> !sense_en);

    // R3: the sense current never flows with the low-side driver enabled.
    a_r3_sense_needs_lowside_off: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |-> lsd_off);

    // R4: the sample strobe follows exactly WIN cycles of sense current.
    a_r4_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
        ocs_start |-> (sense_run == RW'(WIN)));

    // R5: the sample strobe lasts a single cycle.
    a_r5_ocs_single: assert property (@(posedge clk) disable iff (!rst_n)
        ocs_start |=> !ocs_start);

    // R6: the ramp strobe lasts a single cycle, with the low-side driver released.
    a_r6_ss_single: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |-> (!lsd_off && !sense_en) ##1 !ss_start);

    // R7: running only rises after a ramp completion report.
    a_r7_running_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(ss_done));

    // R9: running drops the cycle after enable is lost.
    a_r9_enable_loss_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !en_trip |=> !running);

endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(
    .TICK_DIV    (TICK_DIV),
    .DELAY_TICKS (DELAY_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bias_ok   (bias_ok),
    .en_trip   (en_trip),
    .ocs_done  (ocs_done),
    .ss_done   (ss_done),
    .lsd_off   (lsd_off),
    .sense_en  (sense_en),
    .ocs_start (ocs_start),
    .ss_start  (ss_start),
    .running   (running)
);

// File: tb/pwrseq_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies inputs at the falling edge and queues
// the outputs expected after the next rising edge; the monitor pops and
// compares them shortly after that rising edge.
module pwrseq_ctrl_test;
    localparam int TB_DIV = 4;
    localparam int TB_DLY = 5;
    localparam int N      = TB_DIV * TB_DLY;

    // Expected output vectors {lsd_off, sense_en, ocs_start, ss_start, running}
    localparam logic [4:0] V_OFF  = 5'b10000;
    localparam logic [4:0] V_SET  = 5'b11000;
    localparam logic [4:0] V_OCS  = 5'b11100;
    localparam logic [4:0] V_SS   = 5'b00010;
    localparam logic [4:0] V_RAMP = 5'b00000;
    localparam logic [4:0] V_RUN  = 5'b00001;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bias_ok = 1'b0, en_trip = 1'b0, ocs_done = 1'b0, ss_done = 1'b0;
    logic lsd_off, sense_en, ocs_start, ss_start, running;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    pwrseq_ctrl #(.TICK_DIV(TB_DIV), .DELAY_TICKS(TB_DLY)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bias_ok   (bias_ok),
        .en_trip   (en_trip),
        .ocs_done  (ocs_done),
        .ss_done   (ss_done),
        .lsd_off   (lsd_off),
        .sense_en  (sense_en),
        .ocs_start (ocs_start),
        .ss_start  (ss_start),
        .running   (running)
    );

    // Driver: one clock of stimulus plus its expected result.
    task automatic cyc(input logic r, input logic b, input logic e,
                       input logic od, input logic sd,
                       input logic [4:0] x, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = r; bias_ok = b; en_trip = e; ocs_done = od; ss_done = sd;
        it.exp = x;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Full settling interval with enable held, ending in the sample strobe.
    task automatic settle_to_sample(input string tag);
        for (int i = 0; i < N; i++) cyc(1, 1, 1, 0, 0, V_SET, tag);
        cyc(1, 1, 1, 0, 0, V_OCS, tag);
    endtask

    // Monitor: compare outputs after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it = sb_q.pop_front();
                act = {lsd_off, sense_en, ocs_start, ss_start, running};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the off outputs even with both flags high.
        repeat (3) cyc(0, 1, 1, 0, 0, V_OFF, "R1 in reset");
        repeat (3) cyc(1, 0, 1, 0, 0, V_OFF, "R1 bias low");
        // R2: bias alone does not start timing.
        repeat (6) cyc(1, 1, 0, 0, 0, V_OFF, "R2 wait for enable");
        // R5: sampler done outside sampling has no effect.
        repeat (2) cyc(1, 1, 0, 1, 0, V_OFF, "R5 done ignored in wait");
        // R3 R4 R10: settle with ss_done held high, then the sample strobe.
        for (int i = 0; i < N; i++) cyc(1, 1, 1, 0, 1, V_SET, "R3 R4 R10 settle");
        cyc(1, 1, 1, 0, 0, V_OCS, "R4 R5 sample strobe");
        repeat (3) cyc(1, 1, 1, 0, 1, V_SET, "R3 R5 R10 sample holds");
        // R6: done starts the ramp.
        cyc(1, 1, 1, 1, 0, V_SS, "R6 ramp strobe");
        repeat (3) cyc(1, 1, 1, 1, 0, V_RAMP, "R5 R6 ramp, done ignored");
        // R7: ramp completion raises running.
        cyc(1, 1, 1, 0, 1, V_RUN, "R7 running");
        repeat (3) cyc(1, 1, 1, 0, 0, V_RUN, "R7 running holds");
        // R9: enable loss from run, then a partial settle interrupted.
        cyc(1, 1, 0, 0, 0, V_OFF, "R9 enable loss in run");
        repeat (7) cyc(1, 1, 1, 0, 0, V_SET, "R9 partial settle");
        cyc(1, 1, 0, 0, 0, V_OFF, "R9 enable loss in settle");
        settle_to_sample("R9 R4 full restart");
        // R8: bias loss coincident with sampler done.
        cyc(1, 0, 1, 1, 0, V_OFF, "R8 bias loss beats done");
        // R2 R9: straight into settle, enable dropped on the expiry edge.
        for (int i = 0; i < N; i++) cyc(1, 1, 1, 0, 0, V_SET, "R2 direct settle");
        cyc(1, 1, 0, 0, 0, V_OFF, "R9 enable loss at expiry");
        // R8: bias loss from run, together with enable loss.
        settle_to_sample("R4 again");
        cyc(1, 1, 1, 1, 0, V_SS, "R6 again");
        cyc(1, 1, 1, 0, 1, V_RUN, "R7 again");
        cyc(1, 0, 0, 0, 1, V_OFF, "R8 bias loss in run");
        repeat (2) cyc(1, 0, 1, 1, 1, V_OFF, "R1 R8 stays off");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule